// File: doc/BRIEF.md
# I2C Command Slave with Stall Watchdog

This block is a slave on a two-wire I2C-compatible bus. It runs entirely on the system clock. It synchronizes and edge-detects the SCL and SDA lines and drives SDA only as an open-drain pull-down enable. A write transaction addressed to it carries a pointer byte and, optionally, one data byte for a small bank of byte registers. A later, separate read transaction returns the 16-bit word selected by that pointer, low byte first.

Two pointer values are served as fixed commands. One returns the firmware version word. The other reports which register raised the alert, or returns an error word when no alert is pending.

A transaction can stall with SCL held low. When that lasts a set number of system-clock cycles, a watchdog returns the block to its startup state. An active-low reset input does the same. After any restart the block stays silent on the bus for a settling interval. Both intervals are parameters counted in system-clock cycles, so that a bench can shorten them.

Top module: `i2c_cmd_slave`

## Requirements
- R1: The block acknowledges, by pulling SDA low during the ninth clock, only a START followed by a 7-bit address equal to DEV_ADDR (sent MSB first, then the R/W bit, 0 = write). For any other address it leaves SDA released until the next START.
- R2: A write transaction carries an address with R/W=0, a pointer byte and then one data byte. The block acknowledges both bytes. The data byte is stored in register number `pointer` when the pointer is below NREG.
- R3: In a write transaction, the third byte and any later byte get no acknowledge and change no register.
- R4: A read transaction (address with R/W=1) returns the 16-bit word selected by the last written pointer, low byte first and then high byte, each MSB first. When the master keeps acknowledging, the low and high bytes alternate.
- R5: Pointer FW_CMD (default 0x09) reads as FW_WORD (default 0x0100).
- R6: Pointer ALERT_CMD (default 0x0A) reads as {0x00, alert_src_i} while alert_i is high, and as 0x8103 while alert_i is low.
- R7: Pointers 0 to NREG-1 read as {0x00, register value}. Every other pointer reads as 0xFFFF.
- R8: After the master sends NACK on a read byte, the block drives SDA no more until the next START.
- R9: sda_oe_o becomes active only while the synchronized SCL is low. A STOP always releases SDA.
- R10: Inside a transaction, if SCL stays low for TIMEOUT_CYC consecutive cycles, the block restarts. SDA is released, all registers are cleared and the pointer returns to 0. The count clears whenever SCL is high or no transaction is open.
- R11: The block restarts while rst is high or ext_rst_n is low. After any restart it ignores the bus, and acknowledges nothing, for SETTLE_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_rst_n | input | 1 | Active-low reset request from the board |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| alert_i | input | 1 | An alert is pending |
| alert_src_i | input | 8 | Number of the register that raised the alert |

## Verification
The assertions check on every cycle the rules that need no history. SDA is released while the block settles, after every STOP and after every restart. A reset request always opens the settling window. The pull-down enable rises only while SCL is low. The stall counter never reaches its limit.

Only the bench scenarios can show the rest. These are the returned word values, the byte order, the address match across all 128 addresses, and the refusal of a third write byte. They also include the silence after a master NACK and the wiping of registers and pointer by a watchdog restart or by the reset pin.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR_BYTE,
    ST_WR_ACK, ST_RD_BYTE, ST_RD_ACK, ST_IGNORE
  } bus_state_t;

  localparam logic [15:0] NO_ALERT_WORD = 16'h8103;
  localparam logic [15:0] UNMAPPED_WORD = 16'hFFFF;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[MSB-1:0], scl_i};
      sda_pipe <= {sda_pipe[MSB-1:0], sda_i};
      scl_q    <= scl_pipe[MSB];
      sda_q    <= sda_pipe[MSB];
    end
  end

  assign scl_s     = scl_pipe[MSB];
  assign sda_s     = sda_pipe[MSB];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_guard.sv
module i2c_guard #(
  parameter int TIMEOUT_CYC = 2_000_000,
  parameter int SETTLE_CYC  = 10_000,
  localparam int WDW = $clog2(TIMEOUT_CYC + 1),
  localparam int SW  = $clog2(SETTLE_CYC + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ext_rst_n,
  input  logic           busy,
  input  logic           scl_s,
  output logic           wipe,
  output logic           hold,
  output logic [WDW-1:0] wd_cnt
);
  logic          expire_q;
  logic [SW-1:0] settle_cnt;

  assign wipe = rst | ~ext_rst_n | expire_q;
  assign hold = (settle_cnt != '0);

  always_ff @(posedge clk) begin
    if (wipe) begin
      settle_cnt <= SW'(SETTLE_CYC);
      wd_cnt     <= '0;
      expire_q   <= 1'b0;
    end else begin
      if (hold) settle_cnt <= settle_cnt - 1'b1;
      if (busy && !scl_s) begin
        if (wd_cnt == WDW'(TIMEOUT_CYC - 1)) begin
          wd_cnt   <= '0;
          expire_q <= 1'b1;
        end else begin
          wd_cnt <= wd_cnt + 1'b1;
        end
      end else begin
        wd_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/i2c_cmd_table.sv
module i2c_cmd_table
  import i2c_cmd_pkg::*;
#(
  parameter int          NREG      = 4,
  parameter logic [7:0]  FW_CMD    = 8'h09,
  parameter logic [7:0]  ALERT_CMD = 8'h0A,
  parameter logic [15:0] FW_WORD   = 16'h0100,
  localparam int AW = $clog2(NREG)
) (
  input  logic        clk,
  input  logic        wipe,
  input  logic        we,
  input  logic [7:0]  waddr,
  input  logic [7:0]  wdata,
  input  logic [7:0]  ptr,
  input  logic        alert_i,
  input  logic [7:0]  alert_src_i,
  output logic [15:0] rd_data
);
  logic [7:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (wipe) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && waddr < 8'(NREG)) begin
      regs[waddr[AW-1:0]] <= wdata;
    end
  end

  always_comb begin
    rd_data = UNMAPPED_WORD;
    if (ptr == FW_CMD)          rd_data = FW_WORD;
    else if (ptr == ALERT_CMD)  rd_data = alert_i ? {8'h00, alert_src_i} : NO_ALERT_WORD;
    else if (ptr < 8'(NREG))    rd_data = {8'h00, regs[ptr[AW-1:0]]};
  end
endmodule

// File: rtl/i2c_cmd_slave.sv
module i2c_cmd_slave
  import i2c_cmd_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h2C,
  parameter int          NREG        = 4,
  parameter logic [7:0]  FW_CMD      = 8'h09,
  parameter logic [7:0]  ALERT_CMD   = 8'h0A,
  parameter logic [15:0] FW_WORD     = 16'h0100,
  parameter int          TIMEOUT_CYC = 2_000_000,
  parameter int          SETTLE_CYC  = 10_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ext_rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       alert_i,
  input  logic [7:0] alert_src_i
);
  localparam int WDW = $clog2(TIMEOUT_CYC + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wipe, hold, busy;
  logic [WDW-1:0] wd_cnt;

  bus_state_t  state;
  logic [3:0]  bit_cnt;
  logic [7:0]  shreg, txsh, ptr, wdata;
  logic [15:0] rd_word, word;
  logic [1:0]  byte_idx;
  logic        rw, hi_sel, mack, we;

  i2c_line_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_guard #(.TIMEOUT_CYC(TIMEOUT_CYC), .SETTLE_CYC(SETTLE_CYC)) u_guard (
    .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .busy(busy), .scl_s(scl_s),
    .wipe(wipe), .hold(hold), .wd_cnt(wd_cnt)
  );

  i2c_cmd_table #(
    .NREG(NREG), .FW_CMD(FW_CMD), .ALERT_CMD(ALERT_CMD), .FW_WORD(FW_WORD)
  ) u_table (
    .clk(clk), .wipe(wipe), .we(we), .waddr(ptr), .wdata(wdata), .ptr(ptr),
    .alert_i(alert_i), .alert_src_i(alert_src_i), .rd_data(word)
  );

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (wipe) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      txsh     <= '0;
      ptr      <= '0;
      wdata    <= '0;
      rd_word  <= '0;
      byte_idx <= '0;
      rw       <= 1'b0;
      hi_sel   <= 1'b0;
      mack     <= 1'b0;
      we       <= 1'b0;
      sda_oe_o <= 1'b0;
    end else begin
      we <= 1'b0;
      if (hold) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (start_det) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        byte_idx <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WR_BYTE: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              shreg   <= {shreg[6:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              if (state == ST_ADDR) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  rw       <= shreg[0];
                  state    <= ST_ADDR_ACK;
                  sda_oe_o <= 1'b1;
                end else begin
                  state <= ST_IGNORE;
                end
              end else if (byte_idx == 2'd0) begin
                ptr      <= shreg;
                byte_idx <= 2'd1;
                state    <= ST_WR_ACK;
                sda_oe_o <= 1'b1;
              end else if (byte_idx == 2'd1) begin
                we       <= 1'b1;
                wdata    <= shreg;
                byte_idx <= 2'd2;
                state    <= ST_WR_ACK;
                sda_oe_o <= 1'b1;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rw) begin
                state    <= ST_RD_BYTE;
                rd_word  <= word;
                txsh     <= word[7:0];
                sda_oe_o <= ~word[7];
                hi_sel   <= 1'b1;
              end else begin
                state    <= ST_WR_BYTE;
                sda_oe_o <= 1'b0;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              state    <= ST_WR_BYTE;
              sda_oe_o <= 1'b0;
            end
          end
          ST_RD_BYTE: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd7) begin
                sda_oe_o <= 1'b0;
                state    <= ST_RD_ACK;
              end else begin
                txsh     <= {txsh[6:0], 1'b0};
                sda_oe_o <= ~txsh[6];
                bit_cnt  <= bit_cnt + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) mack <= ~sda_s;
            if (scl_fall) begin
              bit_cnt <= '0;
              if (mack) begin
                txsh     <= hi_sel ? rd_word[15:8] : rd_word[7:0];
                sda_oe_o <= hi_sel ? ~rd_word[15] : ~rd_word[7];
                hi_sel   <= ~hi_sel;
                state    <= ST_RD_BYTE;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_cmd_slave_chk.sv
module i2c_cmd_slave_chk #(
  parameter int TIMEOUT_CYC = 2_000_000,
  parameter int WDW = 21
) (
  input logic           clk,
  input logic           rst,
  input logic           ext_rst_n,
  input logic           scl_s,
  input logic           stop_det,
  input logic           hold,
  input logic           wipe,
  input logic           sda_oe_o,
  input logic [WDW-1:0] wd_cnt
);
  AST_SILENT_WHILE_SETTLING: assert property (@(posedge clk) disable iff (rst)
    hold |-> !sda_oe_o); // R11
  AST_RESET_PIN_SETTLES: assert property (@(posedge clk) disable iff (rst)
    !ext_rst_n |=> hold); // R11
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe_o); // R9
  AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_o) |-> !scl_s); // R9
  AST_RESTART_RELEASES: assert property (@(posedge clk) disable iff (rst)
    wipe |=> !sda_oe_o); // R10
  AST_STALL_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    wd_cnt < WDW'(TIMEOUT_CYC)); // R10
endmodule

bind i2c_cmd_slave i2c_cmd_slave_chk #(.TIMEOUT_CYC(TIMEOUT_CYC), .WDW(WDW)) u_chk (
  .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .scl_s(scl_s), .stop_det(stop_det),
  .hold(hold), .wipe(wipe), .sda_oe_o(sda_oe_o), .wd_cnt(wd_cnt)
);

// File: tb/test_i2c_cmd_slave.sv
module test_i2c_cmd_slave;
  localparam logic [6:0] DEV = 7'h2C;
  localparam int NREG = 4;
  localparam int TOUT = 200;
  localparam int SETTLE = 20;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_rst_n = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic alert = 1'b0;
  logic [7:0] alert_src = 8'h00;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] shadow [NREG];

  always #4 clk = ~clk;

  i2c_cmd_slave #(.DEV_ADDR(DEV), .NREG(NREG), .TIMEOUT_CYC(TOUT), .SETTLE_CYC(SETTLE)) i_i2c_cmd_slave (
    .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .alert_i(alert), .alert_src_i(alert_src)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic read_bit(output logic v);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); v = sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    logic v;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    read_bit(v);
    ack = ~v;
  endtask

  task automatic read_byte(output logic [7:0] b);
    logic v;
    for (int i = 7; i >= 0; i--) begin read_bit(v); b[i] = v; end
  endtask

  task automatic set_ptr(input logic [7:0] p, output logic ok);
    logic a0, a1;
    bus_start(); write_byte({DEV, 1'b0}, a0); write_byte(p, a1); bus_stop();
    ok = a0 & a1;
  endtask

  task automatic rd_txn(input int n, output logic aack, output logic [31:0] got);
    logic [7:0] v;
    got = '0;
    bus_start(); write_byte({DEV, 1'b1}, aack);
    for (int k = 0; k < n; k++) begin
      read_byte(v); got[8*k +: 8] = v; send_bit(k == n - 1);
    end
    bus_stop();
  endtask

  function automatic logic [15:0] expect_word(input logic [7:0] p);
    if (p == 8'h09) return 16'h0100;
    if (p == 8'h0A) return alert ? {8'h00, alert_src} : 16'h8103;
    if (p < NREG) return {8'h00, shadow[p[1:0]]};
    return 16'hFFFF;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ok, a0, a1, a2, a3;
    logic [31:0] got;
    logic [7:0] b;
    for (int i = 0; i < NREG; i++) shadow[i] = 8'h00;
    wq(5);
    check("R9 reset release", {31'd0, sda_oe}, 32'd0);
    rst = 1'b0;
    // R11: transaction inside the settle window is not acknowledged
    bus_start(); write_byte({DEV, 1'b0}, a0); bus_stop();
    check("R11 settle nack", {31'd0, a0}, 32'd0);
    wq(40);

    // R1: address sweep
    for (int a = 0; a < 128; a++) begin
      bus_start(); write_byte({7'(a), 1'b0}, a0); bus_stop();
      check("R1 address match", {31'd0, a0}, {31'd0, (7'(a) == DEV)});
    end

    // R2: register writes
    for (int r = 0; r < NREG; r++) begin
      shadow[r] = 8'(r * 59 + 17);
      bus_start(); write_byte({DEV, 1'b0}, a0); write_byte(8'(r), a1); write_byte(shadow[r], a2); bus_stop();
      check("R2 write acks", {29'd0, a0, a1, a2}, 32'd7);
    end

    // R4 R5 R6 R7: pointer sweep, low byte then high byte
    for (int p = 0; p < 16; p++) begin
      set_ptr(8'(p), ok);
      rd_txn(2, a0, got);
      check("R4 R5 R6 R7 pointer read", got, {16'h0, expect_word(8'(p))});
    end
    alert = 1'b1; alert_src = 8'h5A;
    set_ptr(8'h0A, ok); rd_txn(2, a0, got);
    check("R6 alert active", got, 32'h0000_005A);
    alert = 1'b0;
    rd_txn(2, a0, got);
    check("R6 alert idle", got, 32'h0000_8103);

    // R4: longer read alternates bytes
    set_ptr(8'h09, ok); rd_txn(4, a0, got);
    check("R4 alternate bytes", got, 32'h0100_0100);

    // R3: third write byte refused
    bus_start(); write_byte({DEV, 1'b0}, a0); write_byte(8'h01, a1); write_byte(8'hA5, a2); write_byte(8'h3C, a3); bus_stop();
    check("R3 third byte nack", {31'd0, a3}, 32'd0);
    shadow[1] = 8'hA5;
    set_ptr(8'h01, ok); rd_txn(2, a0, got);
    check("R3 register kept", got, 32'h0000_00A5);

    // R8: after master NACK the bus reads released
    set_ptr(8'h09, ok);
    bus_start(); write_byte({DEV, 1'b1}, a0); read_byte(b); send_bit(1'b1);
    read_byte(b);
    check("R8 silent after nack", {24'd0, b}, 32'h0000_00FF);
    send_bit(1'b1); bus_stop();
    check("R9 stop release", {31'd0, sda_oe}, 32'd0);

    // R10: stall with SCL low while the slave acknowledges
    set_ptr(8'h09, ok);
    bus_start();
    for (int i = 7; i >= 0; i--) send_bit(DEV[i > 0 ? i - 1 : 0] & (i > 0) | ((i == 0) & 1'b0));
    wq(TOUT / 2);
    check("R10 not early", {31'd0, sda_oe}, 32'd1);
    wq(TOUT);
    check("R10 released", {31'd0, sda_oe}, 32'd0);
    bus_stop(); wq(40);
    for (int i = 0; i < NREG; i++) shadow[i] = 8'h00;
    rd_txn(2, a0, got);
    check("R10 pointer and regs cleared", {a0, got[30:0]}, 32'h8000_0000);

    // R11: reset pin wipes registers and pointer
    bus_start(); write_byte({DEV, 1'b0}, a0); write_byte(8'h03, a1); write_byte(8'h44, a2); bus_stop();
    set_ptr(8'h09, ok);
    ext_rst_n = 1'b0; wq(2); ext_rst_n = 1'b1;
    check("R11 release on pin", {31'd0, sda_oe}, 32'd0);
    wq(40);
    rd_txn(2, a0, got);
    check("R11 pointer default", got, 32'h0000_0000);
    set_ptr(8'h03, ok); rd_txn(2, a0, got);
    check("R11 register cleared", got, 32'h0000_0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule